// File: doc/BRIEF.md
# Battery Protection Fault Controller

This block is the digital decision core of a single-cell protection circuit. Analog comparators sit outside it and hand it plain level signals. These signals report overvoltage, the cell dropping below the charge re-enable threshold, undervoltage, overcurrent in the charge direction, overcurrent in the discharge direction, a short circuit, the presence of a small discharge current, and whether the pack terminal reads below a pull-down detect level or above a pull-up detect level. Each fault must persist for its own programmable number of clock ticks before it counts. The block then latches the fault, raises a sticky flag for the host, and drives two active-high FET disable outputs, one for the charge path and one for the discharge path.

Each qualified fault is released in its own way. An overvoltage is released when the cell falls below the re-enable threshold. Its charge disable is also lifted for as long as a discharge current is seen. A charge overcurrent is released when the pack terminal is pulled low. A discharge overcurrent or short circuit is released when the pack terminal is pulled high. An undervoltage puts the block to sleep, which turns off both FETs. A low on the active-low power-switch input wakes the block and re-arms both enable bits. The host sees one 8-bit status/control register and a separate power-switch latch bit.

Top module: `bp_fault_ctrl`

## Requirements
- R1: A fault takes effect at the clock edge on which its detect input has been sampled high for its delay count (in ticks) of consecutive edges. If the input drops before then, the count restarts from zero. The short-circuit delay is shorter than the overcurrent delay.
- R2: A qualified overvoltage sets register bit 7 and asserts chg_off. It leaves dsg_off low.
- R3: While overvoltage is latched, chg_off is low whenever dsg_i_det is high. A cycle with cell_lo_det high releases the overvoltage latch, but the bit 7 flag stays set.
- R4: A qualified undervoltage sets bit 6, sets asleep, and asserts both chg_off and dsg_off.
- R5: A qualified charge overcurrent sets bit 5 and asserts both outputs. Only pack_lo_det releases it. pack_hi_det has no effect on it.
- R6: A qualified discharge overcurrent or a qualified short circuit sets bit 4 and asserts dsg_off only. Only pack_hi_det releases it. pack_lo_det has no effect on it.
- R7: Register bit 1 is the charge enable and bit 0 is the discharge enable. Both are written by the host. A 0 in bit 1 forces chg_off, and a 0 in bit 0 forces dsg_off.
- R8: Flags in bits 7..4 stay set until a register write carries 0 in that bit. Writing 1 never sets a flag. A fault still qualifying in the write cycle keeps its flag set.
- R9: Bit 3 reads as chg_off and bit 2 reads as dsg_off.
- R10: While asleep, a cycle with pwr_sw_n low (and no qualifying undervoltage) returns the block to active at the next edge and sets bits 1 and 0 to 1.
- R11: pwr_sw_n low clears sw_lat at the next edge in any mode. sw_lat_clr sets it back to 1. In active mode pwr_sw_n does not change chg_off, dsg_off or asleep.
- R12: After reset the register reads 0x03, both outputs and asleep are low, and sw_lat is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ov_det | input | 1 | Cell above overvoltage threshold |
| cell_lo_det | input | 1 | Cell below charge re-enable threshold |
| uv_det | input | 1 | Cell below undervoltage threshold |
| chg_oc_det | input | 1 | Charge-direction overcurrent |
| dsg_oc_det | input | 1 | Discharge-direction overcurrent |
| short_det | input | 1 | Short circuit on sense node |
| dsg_i_det | input | 1 | Small discharge current present |
| pack_lo_det | input | 1 | Pack terminal below pull-down detect level |
| pack_hi_det | input | 1 | Pack terminal above pull-up detect level |
| pwr_sw_n | input | 1 | Power-switch input, active low |
| ctl_wr | input | 1 | Register write strobe |
| ctl_wdata | input | 8 | Register write data |
| ctl_rdata | output | 8 | Register read view |
| sw_lat_clr | input | 1 | Sets the power-switch latch to 1 |
| sw_lat | output | 1 | Power-switch latch (0 after a low) |
| chg_off | output | 1 | Charge FET disable |
| dsg_off | output | 1 | Discharge FET disable |
| asleep | output | 1 | Sleep mode |

## Verification
Take the first edge that samples a detect input high as edge 1. A fault's flag, its latch and the FET outputs then change right after edge D, where D is the fault's delay. Host writes, releases, wake-up and latch changes show after the single edge that samples them. dsg_i_det reaches chg_off with no register in the path. The bench drives at falling edges and samples one falling edge after the counted number of rising edges. It sweeps every fault over hold lengths from 1 to D+1, so the first edge that may show an effect is pinned exactly.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int unsigned NUM_FAULT = 5;

    // detect indices into the qualified-fault vector
    localparam int unsigned FI_OV  = 0;
    localparam int unsigned FI_UV  = 1;
    localparam int unsigned FI_COC = 2;
    localparam int unsigned FI_DOC = 3;
    localparam int unsigned FI_SC  = 4;

    // register bit positions
    localparam int unsigned RB_OV  = 7;
    localparam int unsigned RB_UV  = 6;
    localparam int unsigned RB_COC = 5;
    localparam int unsigned RB_DOC = 4;
    localparam int unsigned RB_CM  = 3;
    localparam int unsigned RB_DM  = 2;
    localparam int unsigned RB_CE  = 1;
    localparam int unsigned RB_DE  = 0;

    typedef struct packed {
        logic ov;
        logic uv;
        logic coc;
        logic doc;
    } flags_t;
endpackage

// File: rtl/bp_qual_timer.sv
module bp_qual_timer #(
    parameter int unsigned DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int unsigned CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        hit = cond && (s_q.cnt == LAST);
        if (!cond)
            s_d.cnt = '0;
        else if (s_q.cnt != LAST)
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= LAST);

    generate
        if (DLY > 1) begin : g_hold
            // R1
            hold_before_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hit |-> $past(cond));
        end
    endgenerate
endmodule

// File: rtl/bp_mode_ctl.sv
module bp_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_hit,
    input  logic ps_n,
    input  logic ps_clr,
    output logic asleep,
    output logic wake,
    output logic ps_lat
);
    typedef struct packed {
        logic asleep;
        logic ps_lat;
    } mode_t;

    mode_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        wake = s_q.asleep && !ps_n && !uv_hit;
        if (uv_hit)
            s_d.asleep = 1'b1;
        else if (wake)
            s_d.asleep = 1'b0;
        if (!ps_n)
            s_d.ps_lat = 1'b0;
        else if (ps_clr)
            s_d.ps_lat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{asleep: 1'b0, ps_lat: 1'b1};
        else        s_q <= s_d;
    end

    assign asleep = s_q.asleep;
    assign ps_lat = s_q.ps_lat;

    // R4
    uv_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_hit |=> s_q.asleep);
    // R10
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.asleep && !ps_n && !uv_hit) |=> !s_q.asleep);
    // R11
    sw_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ps_n |=> !s_q.ps_lat);
endmodule

// File: rtl/bp_fault_state.sv
module bp_fault_state
    import bp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FAULT-1:0] hit,
    input  logic                 cell_lo,
    input  logic                 dsg_i,
    input  logic                 pack_lo,
    input  logic                 pack_hi,
    input  logic                 asleep,
    input  logic                 wake,
    input  logic                 wr_en,
    input  logic [7:0]           wr_data,
    output logic                 chg_off,
    output logic                 dsg_off,
    output logic [7:0]           rd_data
);
    typedef struct packed {
        flags_t flags;
        logic   ov_act;
        logic   coc_act;
        logic   doc_act;
        logic   ce;
        logic   de;
    } fs_t;

    localparam fs_t FS_RST = '{flags: '0, ov_act: 1'b0, coc_act: 1'b0,
                               doc_act: 1'b0, ce: 1'b1, de: 1'b1};

    fs_t  s_d, s_q;
    logic doc_any;

    always_comb begin
        s_d     = s_q;
        doc_any = hit[FI_DOC] || hit[FI_SC];

        // fault latches: a new qualification wins over its release
        if (hit[FI_OV])       s_d.ov_act = 1'b1;
        else if (cell_lo)     s_d.ov_act = 1'b0;
        if (hit[FI_COC])      s_d.coc_act = 1'b1;
        else if (pack_lo)     s_d.coc_act = 1'b0;
        if (doc_any)          s_d.doc_act = 1'b1;
        else if (pack_hi)     s_d.doc_act = 1'b0;

        // host clear by writing 0, then fault sets on top
        if (wr_en) begin
            if (!wr_data[RB_OV])  s_d.flags.ov  = 1'b0;
            if (!wr_data[RB_UV])  s_d.flags.uv  = 1'b0;
            if (!wr_data[RB_COC]) s_d.flags.coc = 1'b0;
            if (!wr_data[RB_DOC]) s_d.flags.doc = 1'b0;
            s_d.ce = wr_data[RB_CE];
            s_d.de = wr_data[RB_DE];
        end
        s_d.flags.ov  = s_d.flags.ov  | hit[FI_OV];
        s_d.flags.uv  = s_d.flags.uv  | hit[FI_UV];
        s_d.flags.coc = s_d.flags.coc | hit[FI_COC];
        s_d.flags.doc = s_d.flags.doc | doc_any;

        if (wake) begin
            s_d.ce = 1'b1;
            s_d.de = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= FS_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        chg_off = asleep || s_q.coc_act || !s_q.ce || (s_q.ov_act && !dsg_i);
        dsg_off = asleep || s_q.coc_act || s_q.doc_act || !s_q.de;
        rd_data = {s_q.flags, chg_off, dsg_off, s_q.ce, s_q.de};
    end

    // R8
    ov_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flags.ov && !(wr_en && !wr_data[RB_OV])) |=> s_q.flags.ov);
    // R8
    flag_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.flags.doc && !hit[FI_DOC] && !hit[FI_SC]) |=> !s_q.flags.doc);
    // R5
    coc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.coc_act && !pack_lo) |=> s_q.coc_act);
    // R6
    doc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.doc_act && !pack_hi) |=> s_q.doc_act);
    // R10
    wake_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (s_q.ce && s_q.de));
endmodule

// File: rtl/bp_fault_ctrl.sv
module bp_fault_ctrl
    import bp_pkg::*;
#(
    parameter int unsigned OV_DLY = 1000,
    parameter int unsigned UV_DLY = 2000,
    parameter int unsigned OC_DLY = 400,
    parameter int unsigned SC_DLY = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ov_det,
    input  logic       cell_lo_det,
    input  logic       uv_det,
    input  logic       chg_oc_det,
    input  logic       dsg_oc_det,
    input  logic       short_det,
    input  logic       dsg_i_det,
    input  logic       pack_lo_det,
    input  logic       pack_hi_det,
    input  logic       pwr_sw_n,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       sw_lat_clr,
    output logic       sw_lat,
    output logic       chg_off,
    output logic       dsg_off,
    output logic       asleep
);
    function automatic int unsigned dly_of(input int unsigned idx);
        case (idx)
            FI_OV:   return OV_DLY;
            FI_UV:   return UV_DLY;
            FI_SC:   return SC_DLY;
            default: return OC_DLY;
        endcase
    endfunction

    logic [NUM_FAULT-1:0] cond_v;
    logic [NUM_FAULT-1:0] hit_v;
    logic                 wake;

    always_comb begin
        cond_v         = '0;
        cond_v[FI_OV]  = ov_det;
        cond_v[FI_UV]  = uv_det;
        cond_v[FI_COC] = chg_oc_det;
        cond_v[FI_DOC] = dsg_oc_det;
        cond_v[FI_SC]  = short_det;
    end

    generate
        for (genvar g = 0; g < NUM_FAULT; g++) begin : g_qual
            bp_qual_timer #(.DLY(dly_of(g))) u_qual (
                .clk   (clk),
                .rst_n (rst_n),
                .cond  (cond_v[g]),
                .hit   (hit_v[g])
            );
        end
    endgenerate

    bp_mode_ctl u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .uv_hit (hit_v[FI_UV]),
        .ps_n   (pwr_sw_n),
        .ps_clr (sw_lat_clr),
        .asleep (asleep),
        .wake   (wake),
        .ps_lat (sw_lat)
    );

    bp_fault_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit_v),
        .cell_lo (cell_lo_det),
        .dsg_i   (dsg_i_det),
        .pack_lo (pack_lo_det),
        .pack_hi (pack_hi_det),
        .asleep  (asleep),
        .wake    (wake),
        .wr_en   (ctl_wr),
        .wr_data (ctl_wdata),
        .chg_off (chg_off),
        .dsg_off (dsg_off),
        .rd_data (ctl_rdata)
    );

    // R4
    sleep_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (chg_off && dsg_off));
    // R11
    active_ps_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && !uv_det && !hit_v[FI_UV]) |=> !asleep);
endmodule

// File: tb/bp_fault_ctrl_bench.sv
`timescale 1ns/1ps
module bp_fault_ctrl_bench;
    localparam int unsigned OVD = 4, UVD = 5, OCD = 4, SCD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ov = 0, cell_lo = 0, uv = 0, coc = 0, doc = 0, sc = 0, dsg_i = 0;
    logic pk_lo = 0, pk_hi = 0, sw_n = 1, wr = 0, lat_clr = 0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic lat, c_off, d_off, slp;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bp_fault_ctrl #(.OV_DLY(OVD), .UV_DLY(UVD), .OC_DLY(OCD), .SC_DLY(SCD)) u_bp_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .ov_det(ov), .cell_lo_det(cell_lo), .uv_det(uv),
        .chg_oc_det(coc), .dsg_oc_det(doc), .short_det(sc), .dsg_i_det(dsg_i),
        .pack_lo_det(pk_lo), .pack_hi_det(pk_hi), .pwr_sw_n(sw_n), .ctl_wr(wr),
        .ctl_wdata(wdata), .ctl_rdata(rdata), .sw_lat_clr(lat_clr), .sw_lat(lat),
        .chg_off(c_off), .dsg_off(d_off), .asleep(slp)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_fault(input int f, input logic v);
        case (f)
            0: ov = v;
            1: uv = v;
            2: coc = v;
            3: doc = v;
            default: sc = v;
        endcase
    endtask

    task automatic host_wr(input logic [7:0] d);
        wr = 1; wdata = d; step(1); wr = 0;
    endtask

    task automatic release_all();
        ov = 0; uv = 0; coc = 0; doc = 0; sc = 0; dsg_i = 0;
        cell_lo = 1; pk_lo = 1; pk_hi = 1; sw_n = 0;
        step(1);
        cell_lo = 0; pk_lo = 0; pk_hi = 0; sw_n = 1;
        lat_clr = 1; host_wr(8'h03); lat_clr = 0;
    endtask

    function automatic int dly_of(input int f);
        case (f)
            0: return OVD;
            1: return UVD;
            4: return SCD;
            default: return OCD;
        endcase
    endfunction

    // expected register value for a fired fault with CE=DE=1
    function automatic int fired_reg(input int f);
        case (f)
            0: return 8'h80 | 8'h08 | 8'h03;          // OV, chg_off
            1: return 8'h40 | 8'h0C | 8'h03;          // UV, both off
            2: return 8'h20 | 8'h0C | 8'h03;          // COC, both off
            default: return 8'h10 | 8'h04 | 8'h03;    // DOC/SC, dsg_off
        endcase
    endfunction

    initial begin
        #200000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1;
        step(1);
        // R12 reset state
        chk("R12 reg", rdata, 8'h03);
        chk("R12 outs", {c_off, d_off, slp}, 0);
        chk("R12 sw_lat", lat, 1);

        // R1 sweep of every fault over hold lengths 1..D+1
        for (int f = 0; f < 5; f++) begin
            for (int len = 1; len <= dly_of(f) + 1; len++) begin
                release_all();
                set_fault(f, 1'b1);
                step(len);
                if (len >= dly_of(f)) begin
                    chk($sformatf("R1 f%0d len%0d reg (R2 R4 R5 R6 R9)", f, len), rdata, fired_reg(f));
                    chk($sformatf("R1 f%0d len%0d outs", f, len), {c_off, d_off},
                        (fired_reg(f) >> 2) & 3);
                    chk($sformatf("R4 f%0d sleep", f), slp, (f == 1) ? 1 : 0);
                end else begin
                    chk($sformatf("R1 f%0d len%0d early", f, len), rdata, 8'h03);
                end
                set_fault(f, 1'b0);
                step(1);
            end
        end

        // R1 restart after a drop
        release_all();
        ov = 1; step(OVD - 1); ov = 0; step(1); ov = 1; step(OVD - 1);
        chk("R1 restart", rdata, 8'h03);
        step(1);
        chk("R1 restart then full hold", rdata, 8'h8B);
        ov = 0; step(1);

        // R3 discharge current and re-enable threshold
        dsg_i = 1; #1;
        chk("R3 dsg_i lifts chg_off", c_off, 0);
        chk("R3 R9 mirror", rdata, 8'h83);
        step(1); dsg_i = 0; #1;
        chk("R3 chg_off back", c_off, 1);
        step(1); cell_lo = 1; step(1); cell_lo = 0;
        chk("R3 release keeps flag", rdata, 8'h83);

        // R5 release only by pack low
        release_all();
        coc = 1; step(OCD); coc = 0; pk_hi = 1; step(2); pk_hi = 0;
        chk("R5 pack_hi ignored", rdata, 8'h2F);
        pk_lo = 1; step(1); pk_lo = 0;
        chk("R5 pack_lo release", rdata, 8'h23);

        // R6 release only by pack high
        release_all();
        sc = 1; step(SCD); sc = 0; pk_lo = 1; step(2); pk_lo = 0;
        chk("R6 pack_lo ignored", rdata, 8'h17);
        pk_hi = 1; step(1); pk_hi = 0;
        chk("R6 pack_hi release", rdata, 8'h13);
        chk("R6 chg path on", c_off, 0);

        // R7 enable bits
        release_all();
        host_wr(8'h02);
        chk("R7 DE=0", rdata, 8'h06);
        host_wr(8'h01);
        chk("R7 CE=0", rdata, 8'h09);
        host_wr(8'h03);
        chk("R7 both on", {c_off, d_off}, 0);

        // R8 writing 1 does not set, set beats clear
        host_wr(8'hF3);
        chk("R8 write ones", rdata, 8'h03);
        ov = 1; step(OVD);
        host_wr(8'h03);
        chk("R8 set beats clear", rdata, 8'h8B);
        ov = 0; step(1);
        host_wr(8'h03);
        chk("R8 cleared, latch on", rdata, 8'h0B);
        cell_lo = 1; step(1); cell_lo = 0;
        chk("R8 latch released", rdata, 8'h03);

        // R10 sleep and wake
        release_all();
        host_wr(8'h00);
        chk("R7 both disabled", rdata, 8'h0C);
        uv = 1; step(UVD); uv = 0;
        chk("R4 asleep", slp, 1);
        step(3);
        chk("R10 stays asleep", {slp, rdata}, {1'b1, 8'h4C});
        sw_n = 0; step(1); sw_n = 1;
        chk("R10 woke", slp, 0);
        chk("R10 enables forced", rdata, 8'h43);
        chk("R11 latched in sleep", lat, 0);
        lat_clr = 1; step(1); lat_clr = 0;
        chk("R11 clear", lat, 1);

        // R11 active mode: switch input only latches
        release_all();
        sw_n = 0; step(1); sw_n = 1;
        chk("R11 active no effect", {slp, c_off, d_off, rdata}, {3'b000, 8'h03});
        step(2);
        chk("R11 latch holds", lat, 0);
        lat_clr = 1; step(1); lat_clr = 0;
        chk("R11 latch cleared", lat, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule